// File: doc/BRIEF.md
# DRAM Refresh Row Address Extender

This block lets a small processor whose built-in refresh counter is only seven bits wide refresh DRAM parts that need 256 refresh rows. It counts the processor's own refresh strobes in an eight-bit counter and, while a refresh cycle is in progress, replaces the processor's address bit 7 with the counter's top bit. The low seven row bits still come from the processor. Each time the processor's 7-bit counter wraps, 128 strobes have gone by, so the counter's top bit changes at that point. The two sources together then walk through all 256 rows.

The refresh strobe is brought into the clock domain through a short synchronizer. The counter steps on the trailing edge of each strobe, so the substituted bit holds steady for the whole of a refresh cycle. A mode input chooses between 128-row parts, where the processor's bit 7 always passes straight through, and 256-row parts. In 128-row mode the counter keeps running, but it has no effect on the output.

Top module: `rowExtend`

## Requirements
- R1: While `refreshN` is high (no refresh), `rowA7` equals `procA7` in either mode.
- R2: In 256-row mode (`wideMode`=1) with `refreshN` low, `rowA7` equals bit 7 of the refresh count, whatever `procA7` is.
- R3: Reset (`rstN` low) clears the refresh count to zero, so the first refresh after reset drives `rowA7`=0.
- R4: The count advances by exactly one per refresh strobe. The step happens no later than the third rising clock edge after `refreshN` returns high, and `rowA7` does not change while `refreshN` stays low.
- R5: The substituted bit stays at one value for 128 consecutive strobes and then flips. Combined with a 7-bit wrapping processor row counter, 256 consecutive refreshes present each of the 256 row addresses exactly once.
- R6: In 128-row mode (`wideMode`=0), `rowA7` equals `procA7` at all times, including during refresh.
- R7: The count keeps advancing during 128-row mode, and switching to 256-row mode exposes the accumulated count.
- R8: The count wraps from 255 to 0, so the 257th refresh after reset again drives `rowA7`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wideMode | input | 1 | 1 = 256-row parts (substitute bit 7), 0 = 128-row parts |
| refreshN | input | 1 | Processor refresh strobe, active low |
| procA7 | input | 1 | Processor address bit 7 |
| rowA7 | output | 1 | Row address bit 7 to the DRAM address multiplexer |

## Verification
The bench builds the block with its defaults: an 8-bit count made of two 4-bit stages and a 2-flop synchronizer. These values keep a full 256-strobe sweep, the 128-strobe flip and the 255-to-0 wrap to a few thousand cycles, so a single run covers them. With the short synchronizer the bench can wait a fixed four cycles after each strobe and know the step has landed. Running a 7-bit processor row model next to the block then lets the bench confirm that every combined row address occurs exactly once.

// File: rtl/rowExtPkg.sv
package rowExtPkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic advance;  // one-cycle pulse: step the refresh count
    logic select;   // drive the count's top bit onto the row line
  } rowExtCtlT;
endpackage

// File: rtl/rowExtCtrl.sv
module rowExtCtrl
  import rowExtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wideMode,
  input  logic      refreshN,
  output rowExtCtlT ctl
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;

  // Bring the strobe into the clock domain. Its idle level is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      lastLevel <= 1'b1;
    end else begin
      syncChain <= {syncChain[TOP-1:0], refreshN};
      lastLevel <= syncChain[TOP];
    end
  end

  always_comb begin
    // Trailing (deasserting) edge of the active-low strobe.
    ctl.advance = syncChain[TOP] & ~lastLevel;
    // The selector follows the raw strobe so it covers the whole refresh cycle.
    ctl.select  = wideMode & ~refreshN;
  end
endmodule

// File: rtl/rowExtPath.sv
module rowExtPath
  import rowExtPkg::*;
#(
  parameter int ROW_BITS   = 8,
  parameter int STAGE_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  rowExtCtlT           ctl,
  input  logic                procA7,
  output logic [ROW_BITS-1:0] rowCount,
  output logic                rowA7
);
  localparam int NUM_STAGES = ROW_BITS / STAGE_BITS;

  logic [NUM_STAGES:0] carry;
  assign carry[0] = ctl.advance;

  // Cascaded counter stages. A stage steps when every stage below it is full.
  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    logic [STAGE_BITS-1:0] nib;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         nib <= '0;
      else if (carry[s]) nib <= nib + 1'b1;
    end
    assign carry[s+1] = carry[s] & (&nib);
    assign rowCount[s*STAGE_BITS +: STAGE_BITS] = nib;
  end

  // 2-to-1 selector on the bit-7 row line.
  assign rowA7 = ctl.select ? rowCount[ROW_BITS-1] : procA7;

  logic unusedTopCarry;
  assign unusedTopCarry = carry[NUM_STAGES];
endmodule

// File: rtl/rowExtend.sv
module rowExtend
  import rowExtPkg::*;
#(
  parameter int ROW_BITS    = 8,
  parameter int STAGE_BITS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic wideMode,
  input  logic refreshN,
  input  logic procA7,
  output logic rowA7
);
  rowExtCtlT           ctl;
  logic [ROW_BITS-1:0] rowCount;

  rowExtCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .refreshN(refreshN), .ctl(ctl)
  );

  rowExtPath #(.ROW_BITS(ROW_BITS), .STAGE_BITS(STAGE_BITS)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .procA7(procA7),
    .rowCount(rowCount), .rowA7(rowA7)
  );
endmodule

// File: rtl/rowExtChecker.sv
module rowExtChecker #(
  parameter int ROW_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wideMode,
  input logic                refreshN,
  input logic                procA7,
  input logic                rowA7,
  input logic [ROW_BITS-1:0] rowCount
);
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    refreshN |-> rowA7 == procA7);

  assert_substitute_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && !refreshN) |-> rowA7 == rowCount[ROW_BITS-1]);

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rowCount != $past(rowCount)) |-> rowCount == ROW_BITS'($past(rowCount) + 1'b1));

  assert_narrow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |-> rowA7 == procA7);
endmodule

bind rowExtend rowExtChecker #(.ROW_BITS(ROW_BITS)) uChk (
  .clk(clk), .rstN(rstN), .wideMode(wideMode), .refreshN(refreshN),
  .procA7(procA7), .rowA7(rowA7), .rowCount(rowCount)
);

// File: tb/tb_rowExtend.sv
module tb_rowExtend;
  logic clk = 1'b0;
  logic rstN;
  logic wideMode;
  logic refreshN;
  logic procA7;
  logic rowA7;

  always #5 clk = ~clk;

  rowExtend dut (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .refreshN(refreshN),
    .procA7(procA7), .rowA7(rowA7)
  );

  int checks = 0;
  int errors = 0;
  logic  expQ[$];
  string reqQ[$];
  event  sampleEv;
  int    strobes = 0;     // refresh strobes since the last reset
  logic [6:0] procRow = '0;
  logic [255:0] seen;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected values and compares them with the output.
  initial forever begin
    @(sampleEv);
    if (expQ.size() > 0) begin
      logic  e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      check(rowA7 === e, r, int'(rowA7), int'(e));
    end
  end

  task automatic expect_row(input logic e, input string req);
    #1;
    expQ.push_back(e);
    reqQ.push_back(req);
    ->sampleEv;
    #1;
  endtask

  // One refresh cycle: strobe low for 3 cycles, then high for 4.
  task automatic do_refresh(input logic expBit, input logic drvA7, input string req);
    @(negedge clk);
    procA7   = drvA7;
    refreshN = 1'b0;
    expect_row(expBit, req);
    seen[{rowA7, procRow}] = 1'b1;
    repeat (3) @(negedge clk);
    expect_row(expBit, "R4 stable");
    refreshN = 1'b1;
    procA7   = ~drvA7;
    expect_row(~drvA7, "R1 after refresh");
    repeat (4) @(negedge clk);
    strobes++;
    procRow++;
  endtask

  function automatic logic count_bit7();
    return logic'((strobes >> 7) & 1);
  endfunction

  initial begin
    rstN = 1'b0; wideMode = 1'b1; refreshN = 1'b0; procA7 = 1'b1; seen = '0;
    repeat (3) @(negedge clk);
    expect_row(1'b0, "R3 reset count");
    refreshN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 pass-through in both modes
    for (int m = 0; m < 2; m++) begin
      wideMode = logic'(m);
      for (int v = 0; v < 2; v++) begin
        procA7 = logic'(v);
        expect_row(logic'(v), "R1 idle");
      end
    end
    wideMode = 1'b1;

    // 256 refreshes in wide mode; drive procA7 opposite to the expected bit
    for (int i = 0; i < 256; i++) begin
      logic e;
      e = count_bit7();
      do_refresh(e, ~e, (i == 128) ? "R5 toggle" : "R2 substitute");
    end
    check($countones(seen) == 256, "R5 coverage", $countones(seen), 256);

    // R8 wrap: 257th refresh brings bit 7 back to 0
    do_refresh(1'b0, 1'b1, "R8 wrap");

    // R6 narrow mode: pass-through during refresh, count still runs
    wideMode = 1'b0;
    for (int i = 0; i < 130; i++) begin
      logic d;
      d = logic'(i & 1);
      do_refresh(d, d, "R6 narrow");
    end

    // R7: count is now 387 mod 256 = 131, bit 7 = 1
    wideMode = 1'b1;
    do_refresh(count_bit7(), 1'b0, "R7 hidden count");
    check(count_bit7() == 1'b1, "R7 model", int'(count_bit7()), 1);

    // R3: reset in mid-count
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    strobes = 0;
    repeat (2) @(negedge clk);
    do_refresh(1'b0, 1'b1, "R3 after reset");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule